// File: doc/BRIEF.md
# Accumulator ALU with Flag Unit

This block is the arithmetic and logic stage of a small accumulator machine. One operand is always the accumulator byte. The other operand is a byte taken from a register, from memory or from an immediate field. Both arrive on input ports. The block computes the result combinationally. It raises a write-enable when that result should be stored. On each clock edge where an operation is executed, it updates a five-bit status register that holds sign, zero, half carry, parity and carry.

Every operation class follows its own rule for which status bits it updates and which fixed values it forces. Arithmetic operations update all five bits. Increment and decrement leave carry alone. Logic operations force half carry and carry to fixed values. Complement touches no status bit. Rotates and the two carry-control operations change carry only. Compare sets the status bits as a subtraction would and produces no write. Increment and decrement work on the second operand byte, because that register is also the destination. All other data operations work on the accumulator.

Top module: `acc_alu`

## Requirements
- R1: Opcode encoding on `op_i`: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 complement, 9 increment, 10 decrement, 11 rotate left, 12 rotate right, 13 rotate left through carry, 14 rotate right through carry, 15 set carry, 16 complement carry. For add (0) and add-with-carry (1), `result_o` is (A + B + c) mod 256, where c is the old carry for opcode 1 and 0 for opcode 0. Carry is set when the sum exceeds 255. Half carry is the carry out of the low-nibble sum.
- R2: For subtract (2) and subtract-with-borrow (3), `result_o` is (A - B - c) mod 256, where c is the old carry for opcode 3 and 0 for opcode 2. Carry is set when A < B + c. Half carry is bit 4 of A[3:0] + (~B)[3:0] + (1 - c).
- R3: Compare (4) updates all five flags exactly as subtract does, and drives `wr_en_o` low.
- R4: For arithmetic, logic, increment and decrement, the sign flag equals result bit 7. The zero flag is 1 when the result is 00h. The parity flag is 1 when the result has an even number of one bits.
- R5: AND sets half carry to 1 and clears carry. OR and XOR clear both half carry and carry.
- R6: Complement (8) gives `result_o` = ~A with `wr_en_o` high, and leaves all flags unchanged.
- R7: Increment (9) and decrement (10) act on B and give B+1 and B-1 mod 256. Carry keeps its value. Half carry is 1 for increment when B[3:0] = Fh, and 1 for decrement when B[3:0] != 0.
- R8: Rotate left gives {A[6:0],A[7]} with carry set to A[7]. Rotate right gives {A[0],A[7:1]} with carry set to A[0]. No other flag changes.
- R9: Rotate left through carry gives {A[6:0],old carry} with carry set to A[7]. Rotate right through carry gives {old carry,A[7:1]} with carry set to A[0]. No other flag changes.
- R10: Set carry forces carry to 1 and complement carry inverts it. Both drive `wr_en_o` low and leave the other four flags unchanged.
- R11: While `exec_i` is low, the flags hold their value.
- R12: After reset, `flags_o` is 00000b. The `flags_o` bit order is [4] sign, [3] zero, [2] half carry, [1] parity, [0] carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Execute strobe; flags update on this edge |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand (register, memory or immediate) |
| result_o | output | 8 | Combinational result |
| wr_en_o | output | 1 | Result is to be written back |
| flags_o | output | 5 | Registered status flags |

## Verification
The arithmetic class is swept with every accumulator value against sixteen second-operand values spaced 11h apart, with incoming carry both 0 and 1. This sweep separates plain operations from their carry-using forms and catches errors in half carry at the nibble boundaries 0Fh/10h. It also covers carry and borrow at 00h/FFh and sign at 7Fh/80h. Logic operations use the same grid. They show whether each class forces its own fixed half-carry and carry values. Unary operations, rotates and carry-control operations run on every byte with both carry values. These runs show which flags each operation may change. An idle stretch with varying inputs confirms that the flags hold.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBB = 5'd3,
        OP_CMP = 5'd4,
        OP_AND = 5'd5,
        OP_OR  = 5'd6,
        OP_XOR = 5'd7,
        OP_CPL = 5'd8,
        OP_INC = 5'd9,
        OP_DEC = 5'd10,
        OP_ROL = 5'd11,
        OP_ROR = 5'd12,
        OP_RCL = 5'd13,
        OP_RCR = 5'd14,
        OP_STC = 5'd15,
        OP_CMC = 5'd16
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flags_t;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cy_o,
    output logic              hc_o
);
    logic [DATA_W-1:0] b_eff;
    logic              c_eff;
    logic [DATA_W:0]   full;
    logic [NIB_W:0]    low;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        c_eff = sub_i ? ~cin_i : cin_i;
        full  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
        low   = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, c_eff};
        sum_o = full[DATA_W-1:0];
        cy_o  = sub_i ? ~full[DATA_W] : full[DATA_W];
        hc_o  = low[NIB_W];
    end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cy_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cy_o
);
    always_comb begin
        res_o = a_i;
        cy_o  = cy_i;
        case (op_i)
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_CPL: res_o = ~a_i;
            OP_ROL: begin
                res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
                cy_o  = a_i[DATA_W-1];
            end
            OP_ROR: begin
                res_o = {a_i[0], a_i[DATA_W-1:1]};
                cy_o  = a_i[0];
            end
            OP_RCL: begin
                res_o = {a_i[DATA_W-2:0], cy_i};
                cy_o  = a_i[DATA_W-1];
            end
            OP_RCR: begin
                res_o = {cy_i, a_i[DATA_W-1:1]};
                cy_o  = a_i[0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic [4:0]        op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [4:0]        flags_o
);
    typedef struct packed {
        flags_t            flags;
        logic [DATA_W-1:0] res;
        logic              wr;
    } step_t;

    alu_op_e op;
    flags_t  flags_q;
    flags_t  flags_d;
    step_t   step;

    logic [DATA_W-1:0] add_a, add_b, add_sum, bit_res;
    logic              add_sub, add_cin, add_cy, add_hc, bit_cy;

    assign op = alu_op_e'(op_i);

    function automatic flags_t data_flags(input flags_t f, input logic [DATA_W-1:0] r);
        flags_t o;
        o   = f;
        o.s = r[DATA_W-1];
        o.z = (r == '0);
        o.p = ~^r;
        return o;
    endfunction

    // operand steering for the shared adder
    always_comb begin
        add_a   = acc_i;
        add_b   = opnd_i;
        add_sub = 1'b0;
        add_cin = 1'b0;
        case (op)
            OP_ADC: add_cin = flags_q.cy;
            OP_SUB, OP_CMP: add_sub = 1'b1;
            OP_SBB: begin
                add_sub = 1'b1;
                add_cin = flags_q.cy;
            end
            OP_INC: begin
                add_a   = opnd_i;
                add_b   = '0;
                add_cin = 1'b1;
            end
            OP_DEC: begin
                add_a   = opnd_i;
                add_b   = {{(DATA_W-1){1'b0}}, 1'b1};
                add_sub = 1'b1;
            end
            default: ;
        endcase
    end

    acc_alu_addsub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_addsub (
        .a_i   (add_a),
        .b_i   (add_b),
        .sub_i (add_sub),
        .cin_i (add_cin),
        .sum_o (add_sum),
        .cy_o  (add_cy),
        .hc_o  (add_hc)
    );

    acc_alu_bitops #(.DATA_W(DATA_W)) u_bitops (
        .op_i  (op),
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .cy_i  (flags_q.cy),
        .res_o (bit_res),
        .cy_o  (bit_cy)
    );

    // per-class result and flag rules
    always_comb begin
        step.flags = flags_q;
        step.res   = '0;
        step.wr    = 1'b0;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
                step.res      = add_sum;
                step.wr       = (op != OP_CMP);
                step.flags    = data_flags(flags_q, add_sum);
                step.flags.ac = add_hc;
                step.flags.cy = add_cy;
            end
            OP_INC, OP_DEC: begin
                step.res      = add_sum;
                step.wr       = 1'b1;
                step.flags    = data_flags(flags_q, add_sum);
                step.flags.ac = add_hc;
            end
            OP_AND, OP_OR, OP_XOR: begin
                step.res      = bit_res;
                step.wr       = 1'b1;
                step.flags    = data_flags(flags_q, bit_res);
                step.flags.ac = (op == OP_AND);
                step.flags.cy = 1'b0;
            end
            OP_CPL: begin
                step.res = bit_res;
                step.wr  = 1'b1;
            end
            OP_ROL, OP_ROR, OP_RCL, OP_RCR: begin
                step.res      = bit_res;
                step.wr       = 1'b1;
                step.flags.cy = bit_cy;
            end
            OP_STC: step.flags.cy = 1'b1;
            OP_CMC: step.flags.cy = ~flags_q.cy;
            default: ;
        endcase
        flags_d = exec_i ? step.flags : flags_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign result_o = step.res;
    assign wr_en_o  = step.wr;
    assign flags_o  = flags_q;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       exec_i,
    input logic [4:0] op_i,
    input logic       wr_en_o,
    input logic [4:0] flags_o
);
    import acc_alu_pkg::*;

    logic rot_op;
    assign rot_op = (op_i == OP_ROL) || (op_i == OP_ROR) || (op_i == OP_RCL) || (op_i == OP_RCR);

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == OP_CMP) |-> !wr_en_o); // R3

    AST_AND_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == OP_AND) |=> (flags_o[2] && !flags_o[0])); // R5

    AST_ORXOR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (op_i == OP_OR || op_i == OP_XOR)) |=> (!flags_o[2] && !flags_o[0])); // R5

    AST_CPL_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == OP_CPL) |=> $stable(flags_o)); // R6

    AST_INCDEC_CY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (op_i == OP_INC || op_i == OP_DEC)) |=> $stable(flags_o[0])); // R7

    AST_ROT_ONLY_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && rot_op) |=> $stable(flags_o[4:1])); // R8 R9

    AST_STC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == OP_STC) |=> (flags_o[0] && $stable(flags_o[4:1]))); // R10

    AST_CMC_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == OP_CMC) |=> (flags_o[0] != $past(flags_o[0]))); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> $stable(flags_o)); // R11
endmodule

bind acc_alu acc_alu_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .exec_i  (exec_i),
    .op_i    (op_i),
    .wr_en_o (wr_en_o),
    .flags_o (flags_o)
);

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_i = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic [7:0] result_o;
    logic       wr_en_o;
    logic [4:0] flags_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [4:0] mflags = '0;
    bit done = 0;

    always #2 clk = ~clk;

    acc_alu u_dut (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i),
        .acc_i(acc_i), .opnd_i(opnd_i), .result_o(result_o),
        .wr_en_o(wr_en_o), .flags_o(flags_o)
    );

    function automatic string tag_of(input int op);
        case (op)
            0, 1: return "R1";
            2, 3: return "R2";
            4: return "R3";
            5, 6, 7: return "R5";
            8: return "R6";
            9, 10: return "R7";
            11, 12: return "R8";
            13, 14: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic int even_par(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return (n % 2 == 0) ? 1 : 0;
    endfunction

    // returns {wr, res[7:0], flags[4:0]}
    function automatic logic [13:0] model(input int op, input int a, input int b, input logic [4:0] f);
        int s = f[4], z = f[3], ac = f[2], p = f[1], cy = f[0];
        int r = 0, wr = 0, c, t;
        bit szp = 0;
        case (op)
            0, 1: begin
                c = (op == 1) ? cy : 0;
                t = a + b + c; r = t & 255; cy = (t > 255);
                ac = ((a & 15) + (b & 15) + c) > 15; wr = 1; szp = 1;
            end
            2, 3, 4: begin
                c = (op == 3) ? cy : 0;
                t = a - b - c; r = t & 255; cy = (t < 0);
                ac = ((a & 15) + ((~b) & 15) + (1 - c)) > 15;
                wr = (op != 4); szp = 1;
            end
            5: begin r = a & b; ac = 1; cy = 0; wr = 1; szp = 1; end
            6: begin r = a | b; ac = 0; cy = 0; wr = 1; szp = 1; end
            7: begin r = a ^ b; ac = 0; cy = 0; wr = 1; szp = 1; end
            8: begin r = (~a) & 255; wr = 1; end
            9: begin r = (b + 1) & 255; ac = ((b & 15) == 15); wr = 1; szp = 1; end
            10: begin r = (b + 255) & 255; ac = ((b & 15) != 0); wr = 1; szp = 1; end
            11: begin r = ((a << 1) | (a >> 7)) & 255; cy = a >> 7; wr = 1; end
            12: begin r = ((a >> 1) | ((a & 1) << 7)) & 255; cy = a & 1; wr = 1; end
            13: begin r = ((a << 1) | cy) & 255; cy = a >> 7; wr = 1; end
            14: begin r = (a >> 1) | (cy << 7); cy = a & 1; wr = 1; end
            15: cy = 1;
            16: cy = 1 - cy;
            default: ;
        endcase
        if (szp) begin s = r >> 7; z = (r == 0); p = even_par(r); end
        return {wr[0], r[7:0], s[0], z[0], ac[0], p[0], cy[0]};
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input int op, input int a, input int b);
        logic [13:0] e;
        op_i = op[4:0]; acc_i = a[7:0]; opnd_i = b[7:0]; exec_i = 1'b1;
        e = model(op, a, b, mflags);
        #1;
        check(tag_of(op), "wr_en", int'(wr_en_o), int'(e[13]));
        if (e[13]) check(tag_of(op), "result", int'(result_o), int'(e[12:5]));
        @(posedge clk); #1;
        check((op <= 7 || op == 9 || op == 10) ? {tag_of(op), "/R4"} : tag_of(op),
              "flags", int'(flags_o), int'(e[4:0]));
        mflags = e[4:0];
    endtask

    task automatic set_cy(input int v);
        run_op(15, 0, 0);
        if (v == 0) run_op(16, 0, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog actual %0d expected <190000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R12", "reset flags", int'(flags_o), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R12", "flags after release", int'(flags_o), 0);

        // arithmetic and compare sweep
        for (int op = 0; op <= 4; op++)
            for (int c = 0; c < 2; c++)
                for (int a = 0; a < 256; a++)
                    for (int j = 0; j < 16; j++) begin
                        set_cy(c);
                        run_op(op, a, j * 17);
                    end
        // logic sweep
        for (int op = 5; op <= 7; op++)
            for (int a = 0; a < 256; a++)
                for (int j = 0; j < 16; j++)
                    run_op(op, a, j * 17);
        // unary, rotate and carry-control on every byte
        for (int op = 8; op <= 16; op++)
            for (int c = 0; c < 2; c++)
                for (int v = 0; v < 256; v++) begin
                    set_cy(c);
                    run_op(op, v, v ^ 8'h5A);
                end
        // idle: flags hold while inputs move
        run_op(2, 8'h00, 8'h01);
        exec_i = 1'b0;
        for (int k = 0; k < 20; k++) begin
            op_i = k[4:0]; acc_i = k[7:0] * 8'd13; opnd_i = k[7:0] * 8'd7;
            @(posedge clk); #1;
            check("R11", "flags idle", int'(flags_o), int'(mflags));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule